// File: doc/BRIEF.md
# Clock Divider Group Update Sequencer

This block moves a set of six clock divider register groups to the divider ratios of a new performance level. A one-cycle start pulse and a 2-bit level index launch a sequence. For each group in turn, the block issues one write strobe with merged write data, and then waits until that group's own busy status bits have all dropped before it touches the next group. When the last group has settled, the block raises a one-cycle done pulse.

The write data is a read-modify-write merge. The divider fields of the selected group are taken from a constant ratio table held inside the block. Every other bit is taken from that group's current register contents, which arrive on `cur_i`. A wait counter guards each group: a group that stays busy too long ends the sequence with an error pulse instead of done.

Group indices are core = 0, core-auxiliary = 1, memory controller = 2, top bus = 3, left bus = 4 and right bus = 5. Lane g of `cur_i` is bits [32g+31:32g]. Lane g of `busy_i` is bits [LANE_W*g+LANE_W-1:LANE_W*g].

Top module: `clkdiv_update_seq`

## Requirements
- R1: After a start, groups are written strictly in the order 0,1,2,3,4,5, each exactly once. At most one bit of `wr_en_o` is high in any cycle, and that bit is the index of the group being written.
- R2: Each write strobe lasts one cycle. The write for group g+1 appears in the cycle after the first clock edge at which group g's busy bits are all observed zero. While any of group g's busy bits is set, no write occurs. With no busy at all, writes come every second cycle.
- R3: Only the low bits of each busy lane count as busy status: 7 for group 0, 2 for group 1, 8 for group 2, 5 for group 3, and 2 each for groups 4 and 5. Higher bits of a lane have no effect.
- R4: Group g has as many divider fields as it has busy bits. Field j is the 3-bit slice [4j+2:4j]. The write data equals the current lane value with those slices replaced, and all other bits are kept.
- R5: The packed field values, per level 0/1/2/3, are:
  - group 0: 01033730/01033730/01031310/01130100
  - group 1: 00000003 at every level
  - group 2: 13111113/13111113/13112117/13113117
  - group 3: 00015473/00015473/00017574/00017775
  - groups 4 and 5: 00000013/00000013/00000014/00000015
  
  All values are hex; level 0 is the fastest.
- R6: Groups 4 and 5 receive identical divider field values for a given level.
- R7: The level is captured at start. A start pulse while a sequence is running is ignored: it changes neither the data written nor the number of writes, and no new sequence follows.
- R8: `done_o` is high for exactly one cycle, in the cycle after the edge at which group 5's busy bits are observed clear. It never coincides with a write.
- R9: If a group is observed busy at TIMEOUT consecutive waiting edges, `err_o` pulses for one cycle, the sequence aborts with no further writes and no done, and the next start is accepted.
- R10: During reset, `wr_en_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch a sequence (accepted only when idle) |
| level_i | input | 2 | Target performance level, captured at start |
| cur_i | input | 6*DATA_W | Current contents of each group register |
| busy_i | input | 6*LANE_W | Per-group busy status lanes |
| wr_en_o | output | 6 | One-hot write strobe per group |
| wr_data_o | output | DATA_W | Merged write data for the strobed group |
| done_o | output | 1 | One-cycle pulse when all groups have settled |
| err_o | output | 1 | One-cycle pulse on a wait timeout |

## Verification
The bench builds the block with TIMEOUT set to 20. This makes a stuck group reach the abort path within a few dozen cycles, so the exact cycle of the error pulse and the recovery afterwards can be checked. It keeps the default busy lane width of 8. Every lane narrower than that therefore carries permanently set bits above its status bits, which tests that those bits are ignored. Random busy durations from zero upward cover both the back-to-back write timing and long stalls.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;
  localparam int unsigned NUM_GRP = 6;
  localparam int unsigned GRP_W   = $clog2(NUM_GRP);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_WAIT} seq_state_e;

  function automatic int unsigned busy_width(int unsigned g);
    case (g)
      0:       return 7;
      1:       return 2;
      2:       return 8;
      3:       return 5;
      default: return 2;
    endcase
  endfunction

  function automatic logic [31:0] fld_mask(int unsigned g);
    logic [31:0] m = '0;
    for (int unsigned j = 0; j < 8; j++)
      if (j < busy_width(g)) m[4*j +: 3] = 3'b111;
    return m;
  endfunction

  // packed divider fields, field j at nibble j
  function automatic logic [31:0] div_row(int unsigned g, logic [1:0] lvl);
    case (g)
      0: case (lvl)
           2'd0, 2'd1: return 32'h0103_3730;
           2'd2:       return 32'h0103_1310;
           default:    return 32'h0113_0100;
         endcase
      1: return 32'h0000_0003;
      2: case (lvl)
           2'd0, 2'd1: return 32'h1311_1113;
           2'd2:       return 32'h1311_2117;
           default:    return 32'h1311_3117;
         endcase
      3: case (lvl)
           2'd0, 2'd1: return 32'h0001_5473;
           2'd2:       return 32'h0001_7574;
           default:    return 32'h0001_7775;
         endcase
      default: case (lvl)
           2'd0, 2'd1: return 32'h0000_0013;
           2'd2:       return 32'h0000_0014;
           default:    return 32'h0000_0015;
         endcase
    endcase
  endfunction
endpackage

// File: rtl/div_rmw_merge.sv
module div_rmw_merge
  import clkdiv_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [GRP_W-1:0]          grp_i,
  input  logic [1:0]                lvl_i,
  input  logic [NUM_GRP*DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0]         data_o
);
  logic [DATA_W-1:0] merged [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
    localparam logic [DATA_W-1:0] MASK = DATA_W'(fld_mask(g));
    assign merged[g] = (cur_i[g*DATA_W +: DATA_W] & ~MASK)
                     | (DATA_W'(div_row(g, lvl_i)) & MASK);
  end

  always_comb begin
    data_o = '0;
    for (int unsigned g = 0; g < NUM_GRP; g++)
      if (grp_i == GRP_W'(g)) data_o = merged[g];
  end
endmodule

// File: rtl/div_busy_watch.sv
module div_busy_watch
  import clkdiv_seq_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic [GRP_W-1:0]          grp_i,
  input  logic [NUM_GRP*LANE_W-1:0] busy_i,
  output logic                      busy_o
);
  logic [NUM_GRP-1:0] lane_busy;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LMASK = LANE_W'((1 << busy_width(g)) - 1);
    assign lane_busy[g] = |(busy_i[g*LANE_W +: LANE_W] & LMASK);
  end

  always_comb begin
    busy_o = 1'b0;
    for (int unsigned g = 0; g < NUM_GRP; g++)
      if (grp_i == GRP_W'(g)) busy_o = lane_busy[g];
  end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl
  import clkdiv_seq_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         level_i,
  input  logic               grp_busy_i,
  output logic [GRP_W-1:0]   grp_o,
  output logic [1:0]         lvl_o,
  output logic [NUM_GRP-1:0] wr_en_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);

  seq_state_e       state_q;
  logic [GRP_W-1:0] grp_q;
  logic [1:0]       lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      grp_q   <= '0;
      lvl_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          lvl_q   <= level_i;
          grp_q   <= '0;
          state_q <= S_WRITE;
        end
        S_WRITE: begin
          cnt_q   <= '0;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (!grp_busy_i) begin
            cnt_q <= '0;
            if (grp_q == GRP_W'(NUM_GRP - 1)) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              grp_q   <= grp_q + 1'b1;
              state_q <= S_WRITE;
            end
          end else if (cnt_q == CNT_W'(TIMEOUT - 1)) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o = '0;
    if (state_q == S_WRITE) wr_en_o[grp_q] = 1'b1;
  end

  assign grp_o  = grp_q;
  assign lvl_o  = lvl_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/clkdiv_update_seq.sv
module clkdiv_update_seq
  import clkdiv_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [1:0]                level_i,
  input  logic [NUM_GRP*DATA_W-1:0] cur_i,
  input  logic [NUM_GRP*LANE_W-1:0] busy_i,
  output logic [NUM_GRP-1:0]        wr_en_o,
  output logic [DATA_W-1:0]         wr_data_o,
  output logic                      done_o,
  output logic                      err_o
);
  logic [GRP_W-1:0] grp;
  logic [1:0]       lvl;
  logic             grp_busy;

  div_seq_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .level_i    (level_i),
    .grp_busy_i (grp_busy),
    .grp_o      (grp),
    .lvl_o      (lvl),
    .wr_en_o    (wr_en_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  div_busy_watch #(.LANE_W(LANE_W)) u_busy (
    .grp_i  (grp),
    .busy_i (busy_i),
    .busy_o (grp_busy)
  );

  div_rmw_merge #(.DATA_W(DATA_W)) u_merge (
    .grp_i  (grp),
    .lvl_i  (lvl),
    .cur_i  (cur_i),
    .data_o (wr_data_o)
  );
endmodule

// File: rtl/clkdiv_update_seq_chk.sv
module clkdiv_update_seq_chk
  import clkdiv_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_GRP*DATA_W-1:0] cur_i,
  input logic [NUM_GRP*LANE_W-1:0] busy_i,
  input logic [NUM_GRP-1:0]        wr_en_o,
  input logic [DATA_W-1:0]         wr_data_o,
  input logic                      done_o,
  input logic                      err_o
);
  localparam logic [DATA_W-1:0] LR_MASK = DATA_W'(fld_mask(4));

  logic [GRP_W:0]      nxt_q;
  logic [DATA_W-1:0]   lr_q;
  logic                prev_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      lr_q  <= '0;
    end else begin
      if (done_o || err_o) nxt_q <= '0;
      else if (|wr_en_o)   nxt_q <= nxt_q + 1'b1;
      if (wr_en_o[4]) lr_q <= wr_data_o & LR_MASK;
    end
  end

  always_comb begin
    prev_busy = 1'b0;
    for (int unsigned g = 0; g + 1 < NUM_GRP; g++)
      if (nxt_q == (GRP_W+1)'(g + 1))
        prev_busy = |(busy_i[g*LANE_W +: LANE_W] & LANE_W'((1 << busy_width(g)) - 1));
  end

  p_onehot_wr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  p_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |-> (wr_en_o == (NUM_GRP'(1) << nxt_q)));
  p_single_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |=> (wr_en_o == '0));
  p_wait_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|wr_en_o) && !wr_en_o[0]) |-> !$past(prev_busy));
  p_lr_same_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o[5] |-> ((wr_data_o & LR_MASK) == lr_q));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!err_o && wr_en_o == '0));
  p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_keep
    localparam logic [DATA_W-1:0] KMASK = ~DATA_W'(fld_mask(g));
    p_keep_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o[g] |-> (((wr_data_o ^ cur_i[g*DATA_W +: DATA_W]) & KMASK) == '0));
  end
endmodule

bind clkdiv_update_seq clkdiv_update_seq_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cur_i     (cur_i),
  .busy_i    (busy_i),
  .wr_en_o   (wr_en_o),
  .wr_data_o (wr_data_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/tb_clkdiv_update_seq.sv
module tb_clkdiv_update_seq;
  localparam int DW = 32, LW = 8, NG = 6, TO = 20;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [1:0] level_i = '0;
  logic [NG*DW-1:0] cur_i = '0;
  logic [NG*LW-1:0] busy_i = '0;
  logic [NG-1:0] wr_en_o;
  logic [DW-1:0] wr_data_o;
  logic done_o, err_o;
  int checks = 0, errors = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  clkdiv_update_seq #(.DATA_W(DW), .LANE_W(LW), .TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .level_i(level_i),
    .cur_i(cur_i), .busy_i(busy_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .err_o(err_o));

  function automatic int bw(int g);
    case (g) 0: return 7; 1: return 2; 2: return 8; 3: return 5; default: return 2; endcase
  endfunction

  function automatic logic [31:0] fmask(int g);
    logic [31:0] m = '0;
    for (int j = 0; j < bw(g); j++) m[4*j +: 3] = 3'b111;
    return m;
  endfunction

  function automatic logic [31:0] row(int g, int lvl);
    logic [31:0] t [4];
    case (g)
      0: t = '{32'h01033730, 32'h01033730, 32'h01031310, 32'h01130100};
      1: t = '{32'h00000003, 32'h00000003, 32'h00000003, 32'h00000003};
      2: t = '{32'h13111113, 32'h13111113, 32'h13112117, 32'h13113117};
      3: t = '{32'h00015473, 32'h00015473, 32'h00017574, 32'h00017775};
      default: t = '{32'h00000013, 32'h00000013, 32'h00000014, 32'h00000015};
    endcase
    return t[lvl];
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  endtask

  task automatic set_lane_status(int g, logic [7:0] v);
    for (int b = 0; b < bw(g); b++) busy_i[g*LW + b] = v[b];
  endtask

  // poke: group during whose wait a stray start is issued; hang: group that never settles
  task automatic run_seq(int lvl, int dmax, int poke, int hang);
    logic [DW-1:0] exp;
    int d, n_it;
    for (int g = 0; g < NG; g++) cur_i[g*DW +: DW] = $urandom;
    @(negedge clk); start_i = 1'b1; level_i = 2'(lvl);
    @(negedge clk); start_i = 1'b0;
    for (int g = 0; g < NG; g++) begin
      chk(wr_en_o == NG'(1) << g, "R1 write order", wr_en_o, NG'(1) << g);
      exp = (cur_i[g*DW +: DW] & ~fmask(g)) | row(g, lvl);
      chk(wr_data_o == exp, "R4 R5 merged data", wr_data_o, exp);
      if (g == 5) chk((wr_data_o & fmask(5)) == row(4, lvl), "R6 right equals left",
                      wr_data_o & fmask(5), row(4, lvl));
      if (g == hang) begin
        set_lane_status(g, 8'(1 << (bw(g) - 1)));
        for (int i = 1; i <= TO + 1; i++) begin
          @(negedge clk);
          chk(err_o == (i == TO + 1), "R9 timeout cycle", err_o, i == TO + 1);
          chk(wr_en_o == '0 && !done_o, "R9 no write while stuck", wr_en_o, 0);
        end
        set_lane_status(g, 8'h00);
        repeat (3) begin
          @(negedge clk);
          chk(wr_en_o == '0 && !done_o && !err_o, "R9 aborted stays idle",
              {wr_en_o, done_o, err_o}, 0);
        end
        return;
      end
      d = $urandom_range(dmax, 0);
      if (d > 0) set_lane_status(g, 8'($urandom_range((1 << bw(g)) - 1, 1)));
      n_it = (d > 0) ? d : 1;
      for (int i = 1; i <= n_it; i++) begin
        @(negedge clk); start_i = 1'b0;
        chk(wr_en_o == '0 && !done_o, "R2 no write while waiting", {wr_en_o, done_o}, 0);
        if (g == poke && i == 1) begin start_i = 1'b1; level_i = 2'(lvl ^ 1); end
        if (i == n_it) set_lane_status(g, 8'h00);
      end
      @(negedge clk); start_i = 1'b0;
    end
    chk(done_o == 1'b1 && wr_en_o == '0, "R8 done after last group", {wr_en_o, done_o}, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done is one cycle", done_o, 0);
    repeat (3) begin
      @(negedge clk);
      chk(wr_en_o == '0 && !err_o, "R7 stray start left no sequence", {wr_en_o, err_o}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20231));
    // permanent ones above each lane's status bits (R3)
    for (int g = 0; g < NG; g++)
      for (int b = bw(g); b < LW; b++) busy_i[g*LW + b] = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_en_o == '0 && !done_o && !err_o, "R10 reset state", {wr_en_o, done_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int l = 0; l < 4; l++) run_seq(l, 0, -1, -1);
    run_seq(2, 3, 2, -1);
    run_seq(3, 1, 5, -1);
    run_seq(1, 2, -1, 3);
    run_seq(0, 4, 0, -1);
    run_seq(2, 0, -1, 0);
    run_seq(3, 6, -1, -1);
    for (int k = 0; k < 30; k++)
      run_seq($urandom_range(3, 0), $urandom_range(5, 0),
              ($urandom_range(3, 0) == 0) ? $urandom_range(5, 0) : -1, -1);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule